// File: doc/BRIEF.md
# Programmable SD Card Clock Divider

This block derives the SD card clock from a fast core clock. A software-written 11-bit divisor field holds the division ratio minus two, so a field value of V divides the core clock by V+2. Card identification needs a slow clock and bulk transfer needs a fast one. A mode input therefore picks between two ratios. In identification mode the whole field sets the ratio. In transfer mode only the three low bits set it, which gives ratios 2 to 9. A hold input forces the whole field to be used in both modes, for systems whose core clock is too fast for the short ratio.

The generated clock is glitch-free with respect to ratio changes. The ratio in use is captured once per SD clock period, at the period's first core cycle. A register write or a mode change made partway through a period therefore takes effect only from the next period. Alongside the clock, the block gives the command and data shift logic two one-cycle strobes. One marks the first core cycle of each high phase and the other the first core cycle of each low phase.

Top module: `sdclk_divider`

## Requirements
- R1: While reset is applied, `div_value` reads 507 (a divide ratio of 509), and `sd_clk`, `sd_rise` and `sd_fall` are all low.
- R2: A cycle with `div_we` high loads `div_wdata` into the divisor field, and `div_value` shows it from the next cycle. Any 11-bit value is accepted, including 0 and 0x7FF. Without `div_we` the field keeps its value.
- R3: With `xfer_mode` low, one `sd_clk` period lasts `div_value`+2 core cycles.
- R4: With `xfer_mode` high and `hold_full_div` low, one period lasts `div_value[2:0]`+2 core cycles, and bits 10:3 of the field have no effect.
- R5: With `hold_full_div` high, one period lasts `div_value`+2 core cycles whatever the level of `xfer_mode`.
- R6: Each period of ratio N starts with a high phase of ceil(N/2) core cycles, followed by a low phase of floor(N/2) core cycles. For odd N the high phase is one cycle longer.
- R7: The ratio of a period is fixed by the divisor field and mode inputs as seen at the core clock edge that starts that period. A change made later in the period does not alter its length.
- R8: `sd_rise` is high for exactly the first core cycle in which `sd_clk` is high after being low. `sd_fall` is high for exactly the first core cycle in which `sd_clk` is low after being high. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_we | input | 1 | Write strobe for the divisor field |
| div_wdata | input | 11 | New divisor field value (ratio minus two) |
| xfer_mode | input | 1 | 1 = data transfer mode (short ratio), 0 = identification mode (full ratio) |
| hold_full_div | input | 1 | 1 = use the full field in every mode |
| div_value | output | 11 | Current divisor field |
| sd_clk | output | 1 | Generated SD clock |
| sd_rise | output | 1 | One-cycle strobe at the start of each high phase |
| sd_fall | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
A wrong count, a wrong captured ratio or a wrong phase split inside the divider shows up as a high or low phase of the wrong length. This is visible within one SD clock period, at the rising strobe that closes it. A ratio captured mid-period instead of at the boundary shortens or stretches the period in which the change was made, so the bench measures the period during which a write or a mode change happens. A strobe register that is out of step with the clock register shows up in the very cycle of the next edge.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Which part of the divisor field sets the ratio of the next period.
  typedef enum logic {
    SEL_FULL  = 1'b0,
    SEL_SHORT = 1'b1
  } ratio_sel_e;

endpackage

// File: rtl/sdclk_divreg.sv
module sdclk_divreg #(
  parameter int DIV_W   = 11,
  parameter int RST_DIV = 507
) (
  input  logic             clk_core,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] field_q
);

  localparam logic [DIV_W-1:0] FIELD_RST = DIV_W'(RST_DIV);

  logic [DIV_W-1:0] field_d;

  always_comb begin
    field_d = field_q;
    if (wr_en) begin
      field_d = wr_data;
    end
  end

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= FIELD_RST;
    end else if (wr_en) begin
      field_q <= field_d;
    end
  end

endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 11,
  parameter int SHORT_W = 3
) (
  input  logic [DIV_W-1:0] field,
  input  logic             xfer_mode,
  input  logic             hold_full,
  output logic [DIV_W:0]   ratio
);

  localparam int NW = DIV_W + 1;

  ratio_sel_e       sel;
  logic [NW-1:0]    full_ratio;
  logic [NW-1:0]    short_ratio;

  assign full_ratio = {1'b0, field} + NW'(2);

  generate
    if (SHORT_W < DIV_W) begin : g_short
      assign short_ratio = {{(NW - SHORT_W){1'b0}}, field[SHORT_W-1:0]} + NW'(2);
    end else begin : g_noshort
      assign short_ratio = full_ratio;
    end
  endgenerate

  always_comb begin
    sel = SEL_FULL;
    if (xfer_mode && !hold_full) begin
      sel = SEL_SHORT;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SHORT: ratio = short_ratio;
      default:   ratio = full_ratio;
    endcase
  end

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
  parameter int NW    = 12,
  parameter int RST_N = 509
) (
  input  logic          clk_core,
  input  logic          rst_n,
  input  logic [NW-1:0] next_ratio,
  output logic          sd_clk,
  output logic          sd_rise,
  output logic          sd_fall
);

  localparam logic [NW-1:0] CNT_RST = NW'(RST_N - 1);
  localparam logic [NW-1:0] PER_RST = NW'(RST_N);
  localparam logic [NW-1:0] HI_RST  = NW'((RST_N + 1) / 2);

  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] per_q, per_d;
  logic [NW-1:0] hi_q, hi_d;
  logic          clk_q, clk_d;
  logic          rise_q, rise_d;
  logic          fall_q, fall_d;
  logic          wrap;

  // Next-state: the ratio is captured only when a period wraps.
  always_comb begin
    wrap  = (cnt_q == (per_q - NW'(1)));
    cnt_d = cnt_q + NW'(1);
    per_d = per_q;
    hi_d  = hi_q;
    if (wrap) begin
      cnt_d = '0;
      per_d = next_ratio;
      hi_d  = (next_ratio + NW'(1)) >> 1;
    end
    clk_d  = (cnt_d < hi_d);
    rise_d = clk_d & ~clk_q;
    fall_d = ~clk_d & clk_q;
  end

  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      per_q  <= PER_RST;
      hi_q   <= HI_RST;
      clk_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      hi_q   <= hi_d;
      clk_q  <= clk_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign sd_clk  = clk_q;
  assign sd_rise = rise_q;
  assign sd_fall = fall_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int DIV_W   = 11,
  parameter int SHORT_W = 3,
  parameter int RST_DIV = 507
) (
  input  logic             clk_core,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             xfer_mode,
  input  logic             hold_full_div,
  output logic [DIV_W-1:0] div_value,
  output logic             sd_clk,
  output logic             sd_rise,
  output logic             sd_fall
);

  localparam int NW = DIV_W + 1;

  logic          rst_meta_q;
  logic          rst_sync_n;
  logic [NW-1:0] sel_ratio;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sdclk_divreg #(
    .DIV_W   (DIV_W),
    .RST_DIV (RST_DIV)
  ) u_divreg (
    .clk_core (clk_core),
    .rst_n    (rst_sync_n),
    .wr_en    (div_we),
    .wr_data  (div_wdata),
    .field_q  (div_value)
  );

  sdclk_ratio_sel #(
    .DIV_W   (DIV_W),
    .SHORT_W (SHORT_W)
  ) u_sel (
    .field     (div_value),
    .xfer_mode (xfer_mode),
    .hold_full (hold_full_div),
    .ratio     (sel_ratio)
  );

  sdclk_phase_gen #(
    .NW    (NW),
    .RST_N (RST_DIV + 2)
  ) u_phase (
    .clk_core   (clk_core),
    .rst_n      (rst_sync_n),
    .next_ratio (sel_ratio),
    .sd_clk     (sd_clk),
    .sd_rise    (sd_rise),
    .sd_fall    (sd_fall)
  );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
  parameter int DIV_W = 11
) (
  input logic             clk_core,
  input logic             rst_q,
  input logic             div_we,
  input logic [DIV_W-1:0] div_wdata,
  input logic [DIV_W-1:0] div_value,
  input logic             sd_clk,
  input logic             sd_rise,
  input logic             sd_fall
);

  AST_STROBE_EXCL: assert property (@(posedge clk_core) disable iff (!rst_q)
    !(sd_rise && sd_fall)); // R8

  AST_RISE_LEVEL: assert property (@(posedge clk_core) disable iff (!rst_q)
    sd_rise |-> sd_clk); // R8

  AST_FALL_LEVEL: assert property (@(posedge clk_core) disable iff (!rst_q)
    sd_fall |-> !sd_clk); // R8

  AST_ROSE_STROBE: assert property (@(posedge clk_core) disable iff (!rst_q)
    $rose(sd_clk) |-> sd_rise); // R8

  AST_RISE_SPACING: assert property (@(posedge clk_core) disable iff (!rst_q)
    sd_rise |=> !sd_rise); // R6

  AST_WRITE_LOADS: assert property (@(posedge clk_core) disable iff (!rst_q)
    div_we |=> (div_value == $past(div_wdata))); // R2

  AST_FIELD_HOLDS: assert property (@(posedge clk_core) disable iff (!rst_q)
    !div_we |=> $stable(div_value)); // R2

endmodule

bind sdclk_divider sdclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_core  (clk_core),
  .rst_q     (rst_sync_n),
  .div_we    (div_we),
  .div_wdata (div_wdata),
  .div_value (div_value),
  .sd_clk    (sd_clk),
  .sd_rise   (sd_rise),
  .sd_fall   (sd_fall)
);

// File: tb/sdclk_divider_test.sv
module sdclk_divider_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 190000;

  logic        clk_core;
  logic        rst_n;
  logic        div_we;
  logic [10:0] div_wdata;
  logic        xfer_mode;
  logic        hold_full_div;
  logic [10:0] div_value;
  logic        sd_clk;
  logic        sd_rise;
  logic        sd_fall;

  int checks;
  int errors;
  int cycles;
  int reg_m;
  int cur_n;
  int hi_cnt;
  int lo_cnt;
  int rises;
  bit have_prev;
  bit prev_clk;
  string tag;

  sdclk_divider uut (
    .clk_core      (clk_core),
    .rst_n         (rst_n),
    .div_we        (div_we),
    .div_wdata     (div_wdata),
    .xfer_mode     (xfer_mode),
    .hold_full_div (hold_full_div),
    .div_value     (div_value),
    .sd_clk        (sd_clk),
    .sd_rise       (sd_rise),
    .sd_fall       (sd_fall)
  );

  initial clk_core = 1'b0;
  always #(CLK_PERIOD / 2) clk_core = ~clk_core;

  function automatic int exp_ratio(int field, bit mode, bit hold);
    if (mode && !hold) return (field & 7) + 2;
    return field + 2;
  endfunction

  function automatic string sel_tag(bit mode, bit hold);
    if (hold) return "R5";
    if (mode) return "R4";
    return "R3";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One core cycle: wait for the falling edge, then observe and check.
  task automatic cyc();
    int reg_old;
    bit c;
    @(negedge clk_core);
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
    reg_old = reg_m;
    if (rst_n && div_we) reg_m = int'(div_wdata);
    c = sd_clk;
    if (rst_n) begin
      check(int'(div_value) == reg_m, "R2 field readback", int'(div_value), reg_m);
      if (c != prev_clk || sd_rise || sd_fall) begin
        check(sd_rise == (c && !prev_clk), "R8 rise strobe", int'(sd_rise), int'(c && !prev_clk));
        check(sd_fall == (!c && prev_clk), "R8 fall strobe", int'(sd_fall), int'(!c && prev_clk));
      end
      if (c && !prev_clk) begin
        if (have_prev) begin
          check(hi_cnt == (cur_n + 1) / 2, {tag, " R6 high phase"}, hi_cnt, (cur_n + 1) / 2);
          check(lo_cnt == cur_n / 2, {tag, " R6 low phase"}, lo_cnt, cur_n / 2);
        end
        have_prev = 1'b1;
        cur_n  = exp_ratio(reg_old, xfer_mode, hold_full_div);
        hi_cnt = 0;
        lo_cnt = 0;
        rises++;
      end
      if (c) hi_cnt++; else lo_cnt++;
    end
    prev_clk = c;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wait_rises(int k);
    int target;
    target = rises + k;
    while (rises < target) cyc();
  endtask

  task automatic write_div(int v);
    div_we    = 1'b1;
    div_wdata = 11'(v);
    cyc();
    div_we    = 1'b0;
  endtask

  task automatic set_mode(bit m, bit h);
    xfer_mode     = m;
    hold_full_div = h;
    tag           = sel_tag(m, h);
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; rises = 0;
    reg_m = 507; cur_n = 509; hi_cnt = 0; lo_cnt = 0;
    have_prev = 1'b0; prev_clk = 1'b0; tag = "R3";
    rst_n = 1'b0; div_we = 1'b0; div_wdata = '0;
    xfer_mode = 1'b0; hold_full_div = 1'b0;

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      cyc();
      check(div_value == 11'd507, "R1 reset field", int'(div_value), 507);
      check(!sd_clk && !sd_rise && !sd_fall, "R1 reset outputs",
            int'({sd_clk, sd_rise, sd_fall}), 0);
    end
    rst_n = 1'b1;
    run(4);

    // R3: reset ratio 509 in identification mode, two full periods
    wait_rises(3);

    // R2, R4: zero field, data mode gives divide by two
    write_div(0);
    set_mode(1'b1, 1'b0);
    wait_rises(4);
    // R4: high bits ignored in data mode (0x7F8 -> low bits 0, 0x7FF -> 7)
    write_div(11'h7F8);
    wait_rises(4);
    write_div(11'h7FF);
    wait_rises(4);
    // R5: same field with hold set gives 2049 in data mode
    set_mode(1'b1, 1'b1);
    wait_rises(3);
    // R3: identification mode, odd and even small ratios
    set_mode(1'b0, 1'b0);
    write_div(1);
    wait_rises(4);
    write_div(4);
    wait_rises(4);

    // R7: change mid-period; the running period keeps its ratio
    write_div(20);
    wait_rises(2);
    tag = "R7";
    run(5);
    write_div(1);
    run(3);
    set_mode(1'b1, 1'b0);
    tag = "R7";
    wait_rises(3);
    check(cur_n == 3, "R7 new ratio after boundary", cur_n, 3);

    // Random mix of writes and mode changes at random points
    for (int s = 0; s < 250; s++) begin
      int v;
      v = int'($urandom % 64);
      if (($urandom % 8) == 0) v = int'($urandom % 256);
      run(int'($urandom % 12));
      if ($urandom % 2) write_div(v);
      set_mode(1'($urandom % 2), 1'(($urandom % 4) == 0));
      wait_rises(2);
    end

    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule